// File: doc/BRIEF.md
# Synchronous Serial Slave Port

This block is the slave end of an SPI-style link. An external master supplies a serial clock, an active-low select and serial input data. The block returns eight-bit frames on a serial output and delivers each received byte to the host logic. The serial clock, select and data input are brought into a faster system clock through two-flop synchronisers. Edges are found in that domain, so the system clock must run at least four times faster than the serial clock.

The host loads a transmit byte while select is inactive. It then reads the received byte once the sticky completion flag rises and clears the flag with a one-cycle pulse. Clock polarity, clock phase, bit order and transmit enable are static inputs, changed only while select is inactive. The serial output comes with a separate output-enable, which a pad cell uses to float the line.

Top module: `ssc_slave`

## Requirements
- R1: A frame is eight bits. When the eighth bit is sampled, `rx_data_o` takes the assembled byte and `done_o` is set. `rx_data_o` changes at no other time.
- R2: `lsb_first_i`=0 sends and receives the most significant bit first. `lsb_first_i`=1 sends and receives the least significant bit first.
- R3: With `cpha_i`=0, the first output bit appears as soon as select goes low, before any clock edge. Input is sampled on each leading edge, and the next output bit is shifted on each trailing edge.
- R4: With `cpha_i`=1, each output bit is driven after a leading edge and input is sampled on the trailing edge. Select may stay low across frames. A following frame then transmits the byte just received.
- R5: The leading edge is rising when `cpol_i`=0 (idle low) and falling when `cpol_i`=1 (idle high). Sampling and shifting behave the same for both polarities.
- R6: `sdo_oe_o` is 1 only while `tx_en_i`=1 and select is low. It is 0 whenever `tx_en_i`=0.
- R7: While select is high, serial clock edges have no effect and the shift register keeps its content.
- R8: If select goes high before the eighth bit, the frame is abandoned. `done_o` stays 0, `rx_data_o` is unchanged, and the next select assertion starts a new frame.
- R9: `done_o` stays set until a one-cycle `clr_i` pulse. If a completion and a clear fall in the same cycle, the flag ends set.
- R10: `load_i` writes `tx_data_i` into the shift register only while select is high. A load during an active frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| tx_en_i | input | 1 | Transmitter enable |
| sclk_i | input | 1 | External serial clock |
| sel_ni | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| load_i | input | 1 | Transmit byte write strobe |
| tx_data_i | input | 8 | Transmit byte |
| clr_i | input | 1 | Completion flag clear pulse |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable |
| rx_data_o | output | 8 | Last complete received byte |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
Two events can land on the same system cycle: the completion of the eighth sampled bit and a host clear of the flag. The bench knows how many synchroniser and edge-detector stages lie between a serial clock toggle and the completion. It holds `clr_i` in exactly the cycle in which the flag is set and then requires the flag to remain high. A second kind of overlap is a host load arriving while a frame is in flight. This is judged by the byte the master receives in that frame and the next.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  parameter int unsigned FRAME_W = 8;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = ssc_pkg::SYNC_STAGES,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssc_edge.sv
module ssc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cpol_i,
  output logic lead_o,
  output logic trail_o
);
  logic sclk_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise = sclk_i & ~sclk_q;
  assign fall = ~sclk_i & sclk_q;
  // leading edge leaves the idle level
  assign lead_o  = cpol_i ? fall : rise;
  assign trail_o = cpol_i ? rise : fall;

  assert_one_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_o, trail_o}));
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int unsigned W = ssc_pkg::FRAME_W,
  localparam int unsigned CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_act_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         cpha_i,
  input  logic         lsb_first_i,
  input  logic         sdi_i,
  input  logic         load_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         clr_i,
  output logic         sdo_bit_o,
  output logic [W-1:0] rx_data_o,
  output logic         done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q, rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             smp_q, pend_q, tx_q, done_q;
  logic             complete;

  function automatic logic [W-1:0] push(input logic [W-1:0] v, input logic b, input logic lsb);
    return lsb ? {b, v[W-1:1]} : {v[W-2:0], b};
  endfunction

  function automatic logic head(input logic [W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[W-1];
  endfunction

  assign complete = sel_act_i & sample_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
      tx_q   <= 1'b0;
    end else if (!sel_act_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      if (load_i) sr_q <= tx_data_i;
    end else if (sample_i) begin
      if (cnt_q == LAST) begin
        sr_q   <= push(sr_q, sdi_i, lsb_first_i);
        rx_q   <= push(sr_q, sdi_i, lsb_first_i);
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        smp_q  <= sdi_i;
        pend_q <= 1'b1;
        cnt_q  <= cnt_q + 1'b1;
      end
    end else if (shift_i) begin
      // sampled bit enters the register on the shift edge
      if (pend_q) begin
        sr_q   <= push(sr_q, smp_q, lsb_first_i);
        pend_q <= 1'b0;
      end
      if (cpha_i)
        tx_q <= head(pend_q ? push(sr_q, smp_q, lsb_first_i) : sr_q, lsb_first_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       done_q <= 1'b0;
    else if (complete) done_q <= 1'b1;
    else if (clr_i)    done_q <= 1'b0;
  end

  assign sdo_bit_o = cpha_i ? tx_q : head(sr_q, lsb_first_i);
  assign rx_data_o = rx_q;
  assign done_o    = done_q;

  assert_rx_only_on_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_q) |-> done_q);
  assert_idle_keeps_sr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_act_i && !load_i) |=> $stable(sr_q));
  assert_abort_clears_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_act_i |=> (cnt_q == '0) && !pend_q);
  assert_done_falls_on_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(clr_i));
  assert_no_load_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act_i && !sample_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/ssc_slave.sv
module ssc_slave #(
  parameter int unsigned W = ssc_pkg::FRAME_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         lsb_first_i,
  input  logic         tx_en_i,
  input  logic         sclk_i,
  input  logic         sel_ni,
  input  logic         sdi_i,
  input  logic         load_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         clr_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [W-1:0] rx_data_o,
  output logic         done_o
);
  logic sclk_s, sel_n_s, sdi_s;
  logic lead, trail, sel_act;

  ssc_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sel_ni, sdi_i}),
    .q_o   ({sclk_s, sel_n_s, sdi_s})
  );

  ssc_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_s),
    .cpol_i (cpol_i),
    .lead_o (lead),
    .trail_o(trail)
  );

  assign sel_act = ~sel_n_s;

  ssc_shifter #(.W(W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_act_i  (sel_act),
    .sample_i   (cpha_i ? trail : lead),
    .shift_i    (cpha_i ? lead : trail),
    .cpha_i     (cpha_i),
    .lsb_first_i(lsb_first_i),
    .sdi_i      (sdi_s),
    .load_i     (load_i),
    .tx_data_i  (tx_data_i),
    .clr_i      (clr_i),
    .sdo_bit_o  (sdo_o),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o)
  );

  assign sdo_oe_o = tx_en_i & sel_act;

  assert_oe_needs_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !sel_n_s && tx_en_i);
endmodule

// File: tb/ssc_slave_bench.sv
`timescale 1ns/1ps
module ssc_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, lsbf = 0, ten = 1;
  logic sclk = 0, sel_n = 1, sdi = 0, load = 0, clr = 0;
  logic [7:0] txd = '0;
  logic sdo, sdo_oe, done;
  logic [7:0] rxd;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_rx;

  always #2.5 clk = ~clk;

  ssc_slave u_ssc_slave (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsbf),
    .tx_en_i(ten), .sclk_i(sclk), .sel_ni(sel_n), .sdi_i(sdi), .load_i(load),
    .tx_data_i(txd), .clr_i(clr), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .rx_data_o(rxd), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_idx(input int i, input bit lsb);
    return lsb ? i : 7 - i;
  endfunction

  task automatic pulse_clr();
    clr = 1; wt(1); clr = 0; wt(1);
  endtask

  // serial clock toggle; optional clear aimed at the completion cycle
  task automatic tog(input bit collide);
    sclk = ~sclk;
    if (collide) begin
      repeat (2) @(posedge clk);
      @(negedge clk) clr = 1;
      @(negedge clk) clr = 0;
    end
    wt(H);
  endtask

  task automatic frame(input bit do_load, input logic [7:0] stx, input logic [7:0] mtx,
                       input int nbits, input bit release_sel, input bit collide,
                       input bit mid_load);
    if (do_load) begin
      txd = stx; load = 1; wt(1); load = 0; wt(1);
    end
    sel_n = 0;
    m_rx = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        sdi = mtx[bit_idx(i, lsbf)];
        wt(H);
        m_rx[bit_idx(i, lsbf)] = sdo;
        if (mid_load && i == 2) begin
          txd = ~stx; load = 1; wt(1); load = 0;
        end
        tog(collide && i == nbits - 1);
        tog(1'b0);
      end else begin
        tog(1'b0);
        sdi = mtx[bit_idx(i, lsbf)];
        m_rx[bit_idx(i, lsbf)] = sdo;
        if (mid_load && i == 2) begin
          txd = ~stx; load = 1; wt(1); load = 0;
        end
        tog(collide && i == nbits - 1);
      end
    end
    wt(4);
    if (release_sel) begin
      sel_n = 1; wt(H);
    end
  endtask

  task automatic set_mode(input bit p, input bit h, input bit l);
    cpol = p; cpha = h; lsbf = l; sclk = p; wt(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] a, b, prev;
    void'($urandom(32'd2718));
    wt(4); rst_n = 1; wt(4);
    chk(done == 0, "R1", "reset done", done, 0);
    chk(rxd == 0, "R1", "reset rx", rxd, 0);
    chk(sdo_oe == 0, "R6", "reset oe", sdo_oe, 0);

    // R3 first bit before any edge, phase 0
    set_mode(0, 0, 0);
    txd = 8'hA5; load = 1; wt(1); load = 0; wt(1);
    sel_n = 0; wt(H);
    chk(sdo == 1'b1 && sdo_oe, "R3", "first bit on select", {sdo_oe, sdo}, 2'b11);
    sel_n = 1; wt(H);
    chk(done == 0, "R8", "no edges no done", done, 0);

    // directed per mode, R1 R2 R3 R4 R5
    for (int m = 0; m < 8; m++) begin
      set_mode(m[0], m[1], m[2]);
      a = 8'h3C ^ 8'(m * 37); b = 8'hC1 ^ 8'(m * 11);
      pulse_clr();
      frame(1, a, b, 8, 1, 0, 0);
      chk(m_rx == a, m[1] ? "R4" : "R3", "master received", m_rx, a);
      chk(rxd == b, m[2] ? "R2" : "R5", "slave received", rxd, b);
      chk(done == 1, "R1", "done set", done, 1);
    end

    // R9 sticky then clear
    wt(20);
    chk(done == 1, "R9", "done sticky", done, 1);
    pulse_clr();
    chk(done == 0, "R9", "done cleared", done, 0);

    // R9 collision of completion and clear
    set_mode(1, 0, 0);
    frame(1, 8'h5A, 8'h96, 8, 1, 1, 0);
    chk(done == 1, "R9", "set wins over clear", done, 1);
    chk(rxd == 8'h96, "R1", "rx on collision", rxd, 8'h96);

    // R8 abort mid byte
    pulse_clr();
    prev = rxd;
    set_mode(0, 1, 0);
    frame(1, 8'h11, 8'hEE, 5, 1, 0, 0);
    chk(done == 0, "R8", "abort no done", done, 0);
    chk(rxd == prev, "R8", "abort rx held", rxd, prev);
    frame(1, 8'h2B, 8'h71, 8, 1, 0, 0);
    chk(rxd == 8'h71, "R8", "fresh frame rx", rxd, 8'h71);
    chk(m_rx == 8'h2B, "R8", "fresh frame tx", m_rx, 8'h2B);

    // R4 back-to-back with select held, R10 load ignored while active
    pulse_clr();
    set_mode(0, 1, 1);
    frame(1, 8'h4D, 8'hB2, 8, 0, 0, 0);
    chk(rxd == 8'hB2, "R4", "b2b first rx", rxd, 8'hB2);
    pulse_clr();
    frame(1, 8'h00, 8'h63, 8, 1, 0, 0);
    chk(m_rx == 8'hB2, "R10", "b2b tx is received byte", m_rx, 8'hB2);
    chk(rxd == 8'h63 && done, "R4", "b2b second rx", rxd, 8'h63);

    // R10 load during active frame, phase 0
    set_mode(1, 0, 1);
    frame(1, 8'hC3, 8'h0F, 8, 1, 0, 1);
    chk(m_rx == 8'hC3, "R10", "mid-frame load ignored", m_rx, 8'hC3);

    // R7 edges while select high leave content
    for (int i = 0; i < 6; i++) begin
      sdi = i[0]; tog(1'b0);
    end
    frame(0, 8'h00, 8'h5E, 8, 1, 0, 0);
    chk(m_rx == 8'h0F, "R7", "content kept while idle", m_rx, 8'h0F);

    // R6 output enable
    ten = 0; sel_n = 0; wt(H);
    chk(sdo_oe == 0, "R6", "oe off when disabled", sdo_oe, 0);
    ten = 1; wt(2);
    chk(sdo_oe == 1, "R6", "oe on when enabled", sdo_oe, 1);
    sel_n = 1; wt(H);
    chk(sdo_oe == 0, "R6", "oe off when deselected", sdo_oe, 0);
    ten = 0;
    set_mode(0, 0, 0);
    frame(1, 8'h9A, 8'h27, 8, 1, 0, 0);
    chk(rxd == 8'h27, "R6", "rx works with tx disabled", rxd, 8'h27);
    ten = 1;

    // random frames
    for (int k = 0; k < 24; k++) begin
      set_mode(1'($urandom), 1'($urandom), 1'($urandom));
      a = 8'($urandom); b = 8'($urandom);
      pulse_clr();
      frame(1, a, b, 8, 1, 0, 0);
      chk(m_rx == a, cpha ? "R4" : "R3", "random master rx", m_rx, a);
      chk(rxd == b && done, lsbf ? "R2" : "R1", "random slave rx", rxd, b);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule